// File: doc/BRIEF.md
# Pixel Format Packer

The block takes one pixel per clock as three 8-bit components and packs them into a stream of 32-bit memory words. The components mean R, G, B for the RGB layouts and Y, U, V for the YUV layouts. A 3-bit format code selects one of seven layouts. A swap bit optionally exchanges the two outer colour components. The block lays out the bytes of each word, keeps only the top bits of each component where the layout is narrow, and inserts an opaque alpha byte where the layout has one. In the 4:2:2 layout it drops every second chroma sample. Bytes that do not fill a whole word are carried over into the next word. A pixel marked as the last of its line forces out any partial word, padded with zeros and tagged as the end of the line.

Both streams use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. A source holds valid and its data until that transfer takes place. The block follows the same rule on its output: once `o_vld` is high, `o_word` and `o_eol` do not change until the sink takes the word. `i_rdy` goes low whenever the output register is full and the sink is not taking it. `i_rdy` also goes low for one cycle after a line's last pixel that needs two words to finish the line. The format code and swap bit must only change between lines, when the block holds no data.

Top module: `pixel_packer`

## Requirements
- R1: Format code 0 gives 3 bytes per pixel (c0, c1, c2 after swap, lowest byte first), packed with no gaps, so four pixels fill exactly three words; bytes beyond bit 31 move into the next word.
- R2: Format code 1 gives a 16-bit value per pixel: bits 15:11 are R[7:3], bits 10:5 are G[7:2] and bits 4:0 are B[7:3]. Two pixels go into each word, with the first pixel in bits 15:0.
- R3: Format code 2 gives one word per pixel with value {8'hFF, R, G, B}, where bits 31:24 hold alpha.
- R4: Format code 3 gives one word per pixel with value {R, G, B, 8'hFF}.
- R5: Format code 5 gives one word per pixel with value {8'hFF, Y, U, V}.
- R6: Format codes 4 and 7 give one byte per pixel (c0), four pixels per word with the first pixel in bits 7:0. The swap bit has no effect in these formats.
- R7: Format code 6 gives the word {V, Y1, U, Y0}, with Y0 in bits 7:0. U and V are taken from the first pixel of each pair. Pairing restarts at each line.
- R8: With the swap bit at 1, codes 0 to 3 exchange c0 and c2 (R and B), and codes 5 and 6 exchange c1 and c2 (U and V). With the swap bit at 0, the components keep their order.
- R9: When a pixel with `i_eol` is accepted, every remaining byte of the line is sent out. The last word of the line has `o_eol` = 1 and its unused upper bytes at zero. No other word has `o_eol` set.
- R10: While `o_vld` is 1 and `o_rdy` is 0, `o_word` and `o_eol` hold. No pixel is lost or repeated under any pattern of back-pressure.
- R11: After reset, `o_vld` is 0 and `i_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fmt | input | 3 | Output layout code |
| cfg_swap | input | 1 | Component exchange enable |
| i_vld | input | 1 | Input pixel valid |
| i_rdy | output | 1 | Block can take a pixel |
| i_c0 | input | 8 | Component 0 (R or Y) |
| i_c1 | input | 8 | Component 1 (G or U) |
| i_c2 | input | 8 | Component 2 (B or V) |
| i_eol | input | 1 | Pixel is the last of its line |
| o_vld | output | 1 | Output word valid |
| o_rdy | input | 1 | Sink takes the word |
| o_word | output | 32 | Packed memory word |
| o_eol | output | 1 | Word closes a line |

## Verification
Every format code is driven with both swap settings, using random component values and random line lengths from one to nine pixels. The line lengths leave 0 to 3 bytes for the end-of-line flush. In the 24-bit layout they also produce the case where the last pixel needs two words. In the 4:2:2 layout they produce lines with an odd pixel count. Random input gaps and random output back-pressure show whether any word is lost, repeated or changed while it is stalled. Because the swap runs are mixed in, a wrong pair of exchanged components shows up even when the byte layout itself is right.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int COMP_W  = 8;
  localparam int WORD_B  = 4;
  localparam int WORD_W  = WORD_B * COMP_W;
  localparam int RES_B   = WORD_B - 1;
  localparam int RES_W   = RES_B * COMP_W;
  localparam int CNT_W   = 3;
  localparam logic [COMP_W-1:0] ALPHA = 8'hFF;

  typedef enum logic [2:0] {
    FMT_RGB24  = 3'd0,
    FMT_RGB565 = 3'd1,
    FMT_ARGB   = 3'd2,
    FMT_RGBA   = 3'd3,
    FMT_MONO   = 3'd4,
    FMT_AYUV   = 3'd5,
    FMT_YUYV   = 3'd6,
    FMT_MONO7  = 3'd7
  } fmt_e;
endpackage

// File: rtl/pp_fmt_map.sv
module pp_fmt_map
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic              swap,
  input  logic [COMP_W-1:0] c0,
  input  logic [COMP_W-1:0] c1,
  input  logic [COMP_W-1:0] c2,
  input  logic              fire,
  input  logic              eol,
  output logic [WORD_W-1:0] bytes,
  output logic [CNT_W-1:0]  nbytes
);
  logic              pair_odd;
  logic [COMP_W-1:0] v_hold;
  logic [COMP_W-1:0] r_s, g_s, b_s, y_s, u_s, v_s;

  // RGB view swaps outer components, YUV view swaps the chroma pair
  always_comb begin
    r_s = swap ? c2 : c0;
    g_s = c1;
    b_s = swap ? c0 : c2;
    y_s = c0;
    u_s = swap ? c2 : c1;
    v_s = swap ? c1 : c2;
  end

  always_comb begin
    bytes  = '0;
    nbytes = 3'd1;
    unique case (fmt)
      FMT_RGB24: begin
        bytes  = {8'd0, b_s, g_s, r_s};
        nbytes = 3'd3;
      end
      FMT_RGB565: begin
        bytes  = {16'd0, r_s[7:3], g_s[7:2], b_s[7:3]};
        nbytes = 3'd2;
      end
      FMT_ARGB: begin
        bytes  = {ALPHA, r_s, g_s, b_s};
        nbytes = 3'd4;
      end
      FMT_RGBA: begin
        bytes  = {r_s, g_s, b_s, ALPHA};
        nbytes = 3'd4;
      end
      FMT_AYUV: begin
        bytes  = {ALPHA, y_s, u_s, v_s};
        nbytes = 3'd4;
      end
      FMT_YUYV: begin
        bytes  = pair_odd ? {16'd0, v_hold, y_s} : {16'd0, u_s, y_s};
        nbytes = 3'd2;
      end
      default: begin
        bytes  = {24'd0, c0};
        nbytes = 3'd1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_odd <= 1'b0;
      v_hold   <= '0;
    end else if (fire) begin
      if (eol || fmt != FMT_YUYV) pair_odd <= 1'b0;
      else                        pair_odd <= ~pair_odd;
      if (fmt == FMT_YUYV && !pair_odd) v_hold <= v_s;
    end
  end

  // R7: an open pair only exists while the 4:2:2 layout is selected
  p_pair_fmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_odd |-> (fmt == FMT_YUYV));
endmodule

// File: rtl/pp_byte_pack.sv
module pp_byte_pack
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  output logic              in_rdy,
  input  logic [WORD_W-1:0] in_bytes,
  input  logic [CNT_W-1:0]  in_n,
  input  logic              in_eol,
  output logic              out_vld,
  input  logic              out_rdy,
  output logic [WORD_W-1:0] out_word,
  output logic              out_eol,
  output logic [1:0]        held_bytes
);
  localparam int CMB_W = WORD_W + RES_W;

  logic [RES_W-1:0] resid;
  logic [1:0]       rcnt;
  logic             flush_pend;
  logic             can_load, fire;
  logic [CMB_W-1:0] comb_v;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] rem;

  assign can_load   = !out_vld || out_rdy;
  assign in_rdy     = can_load && !flush_pend;
  assign fire       = in_vld && in_rdy;
  assign held_bytes = rcnt;

  always_comb begin
    comb_v = {{WORD_W{1'b0}}, resid} | ({{RES_W{1'b0}}, in_bytes} << {rcnt, 3'b000});
    total  = {1'b0, rcnt} + in_n;
    rem    = total - 3'd4;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resid      <= '0;
      rcnt       <= '0;
      flush_pend <= 1'b0;
      out_vld    <= 1'b0;
      out_word   <= '0;
      out_eol    <= 1'b0;
    end else if (flush_pend && can_load) begin
      out_vld    <= 1'b1;
      out_word   <= {{(WORD_W-RES_W){1'b0}}, resid};
      out_eol    <= 1'b1;
      resid      <= '0;
      rcnt       <= '0;
      flush_pend <= 1'b0;
    end else if (fire) begin
      if (total >= 3'd4) begin
        out_vld  <= 1'b1;
        out_word <= comb_v[WORD_W-1:0];
        if (in_eol && rem != 3'd0) begin
          out_eol    <= 1'b0;
          resid      <= comb_v[CMB_W-1:WORD_W];
          rcnt       <= rem[1:0];
          flush_pend <= 1'b1;
        end else begin
          out_eol <= in_eol;
          resid   <= comb_v[CMB_W-1:WORD_W];
          rcnt    <= in_eol ? 2'd0 : rem[1:0];
        end
      end else if (in_eol) begin
        out_vld  <= 1'b1;
        out_word <= comb_v[WORD_W-1:0];
        out_eol  <= 1'b1;
        resid    <= '0;
        rcnt     <= '0;
      end else begin
        out_vld <= 1'b0;
        resid   <= comb_v[RES_W-1:0];
        rcnt    <= total[1:0];
      end
    end else if (out_rdy) begin
      out_vld <= 1'b0;
    end
  end

  // R10: a stalled word keeps its content until taken
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_word) && $stable(out_eol)));
  // R9: no pixel enters while the tail of a line is still waiting to go out
  p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend |-> !in_rdy);
  // R9: a word closing a line leaves nothing behind
  p_eol_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_eol) |-> (rcnt == 2'd0 && !flush_pend));
  // R9: the extra flush cycle always produces a closing word
  p_flush_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pend && can_load) |=> (out_vld && out_eol));
endmodule

// File: rtl/pixel_packer.sv
module pixel_packer
  import pp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_fmt,
  input  logic        cfg_swap,
  input  logic        i_vld,
  output logic        i_rdy,
  input  logic [7:0]  i_c0,
  input  logic [7:0]  i_c1,
  input  logic [7:0]  i_c2,
  input  logic        i_eol,
  output logic        o_vld,
  input  logic        o_rdy,
  output logic [31:0] o_word,
  output logic        o_eol
);
  fmt_e              fmt;
  logic [WORD_W-1:0] px_bytes;
  logic [CNT_W-1:0]  px_n;
  logic              px_fire;
  logic [1:0]        held;

  assign fmt     = fmt_e'(cfg_fmt);
  assign px_fire = i_vld && i_rdy;

  pp_fmt_map u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .fmt    (fmt),
    .swap   (cfg_swap),
    .c0     (i_c0),
    .c1     (i_c1),
    .c2     (i_c2),
    .fire   (px_fire),
    .eol    (i_eol),
    .bytes  (px_bytes),
    .nbytes (px_n)
  );

  pp_byte_pack u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (i_vld),
    .in_rdy     (i_rdy),
    .in_bytes   (px_bytes),
    .in_n       (px_n),
    .in_eol     (i_eol),
    .out_vld    (o_vld),
    .out_rdy    (o_rdy),
    .out_word   (o_word),
    .out_eol    (o_eol),
    .held_bytes (held)
  );

  // R3 R4 R5: whole-word layouts never leave bytes waiting
  p_full_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_ARGB || fmt == FMT_RGBA || fmt == FMT_AYUV) |-> (held == 2'd0));
  // R2 R7: two-byte layouts only ever hold half a word
  p_half_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_RGB565 || fmt == FMT_YUYV) |-> (held == 2'd0 || held == 2'd2));
endmodule

// File: tb/pixel_packer_tb_top.sv
module pixel_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_fmt = 3'd0;
  logic        cfg_swap = 1'b0;
  logic        i_vld = 1'b0;
  logic        i_rdy;
  logic [7:0]  i_c0 = 8'd0, i_c1 = 8'd0, i_c2 = 8'd0;
  logic        i_eol = 1'b0;
  logic        o_vld;
  logic        o_rdy = 1'b0;
  logic [31:0] o_word;
  logic        o_eol;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  bq[$];
  int          ph = 0;
  logic [7:0]  vsave = 8'd0;

  logic        prev_stall = 1'b0;
  logic [31:0] prev_word = '0;
  logic        prev_eol = 1'b0;

  always #2 clk = ~clk;

  pixel_packer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_swap(cfg_swap),
    .i_vld(i_vld), .i_rdy(i_rdy), .i_c0(i_c0), .i_c1(i_c1), .i_c2(i_c2),
    .i_eol(i_eol), .o_vld(o_vld), .o_rdy(o_rdy), .o_word(o_word), .o_eol(o_eol)
  );

  function automatic string fmt_tag();
    if (cfg_fmt == 3'd4 || cfg_fmt == 3'd7) return "R6";
    if (cfg_swap) return "R8";
    case (cfg_fmt)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd5: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic void emit(bit last);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (bq.size() > 0) w[8*k +: 8] = bq.pop_front();
    exp_q.push_back({last, w});
    tag_q.push_back(last ? "R9" : fmt_tag());
  endfunction

  // Reference: byte stream per requirement R1..R8, word building per R9
  function automatic void model_pix(logic [7:0] a, logic [7:0] b, logic [7:0] c, bit eol);
    logic [7:0] r, g, bl, u, v;
    logic [15:0] h;
    r  = cfg_swap ? c : a;  g = b;  bl = cfg_swap ? a : c;
    u  = cfg_swap ? c : b;  v = cfg_swap ? b : c;
    case (cfg_fmt)
      3'd0: begin bq.push_back(r); bq.push_back(g); bq.push_back(bl); end
      3'd1: begin
        h = {r[7:3], g[7:2], bl[7:3]};
        bq.push_back(h[7:0]); bq.push_back(h[15:8]);
      end
      3'd2: begin bq.push_back(bl); bq.push_back(g); bq.push_back(r); bq.push_back(8'hFF); end
      3'd3: begin bq.push_back(8'hFF); bq.push_back(bl); bq.push_back(g); bq.push_back(r); end
      3'd5: begin bq.push_back(v); bq.push_back(u); bq.push_back(a); bq.push_back(8'hFF); end
      3'd6: begin
        if (ph == 0) begin bq.push_back(a); bq.push_back(u); vsave = v; ph = 1; end
        else begin bq.push_back(a); bq.push_back(vsave); ph = 0; end
      end
      default: bq.push_back(a);
    endcase
    if (eol) begin
      ph = 0;
      while (bq.size() > 0) emit(bq.size() <= 4);
    end else begin
      while (bq.size() >= 4) emit(1'b0);
    end
  endfunction

  // Compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        n_cmp++;
        if (!o_vld || o_word != prev_word || o_eol != prev_eol) begin
          n_bad++;
          $display("FAIL R10 stalled word changed: got vld=%0b %h eol=%0b exp vld=1 %h eol=%0b",
                   o_vld, o_word, o_eol, prev_word, prev_eol);
        end
      end
      if (o_vld && o_rdy) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R10 extra word: got %h eol=%0b exp none", o_word, o_eol);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (o_word != e[31:0] || o_eol != e[32]) begin
            n_bad++;
            $display("FAIL %s fmt=%0d swap=%0b: got %h eol=%0b exp %h eol=%0b",
                     t, cfg_fmt, cfg_swap, o_word, o_eol, e[31:0], e[32]);
          end
        end
      end
      if (i_vld && i_rdy) model_pix(i_c0, i_c1, i_c2, i_eol);
      prev_stall = o_vld && !o_rdy;
      prev_word  = o_word;
      prev_eol   = o_eol;
    end
  end

  // Random sink back-pressure
  always @(posedge clk) begin
    #1;
    o_rdy <= ($urandom_range(0, 9) < 6);
  end

  task automatic send_pix(bit eol);
    while ($urandom_range(0, 3) == 0) begin
      i_vld = 1'b0;
      @(posedge clk); #1;
    end
    i_vld = 1'b1;
    i_c0 = 8'($urandom); i_c1 = 8'($urandom); i_c2 = 8'($urandom);
    i_eol = eol;
    forever begin
      @(negedge clk);
      if (i_rdy) break;
    end
    @(posedge clk); #1;
    i_vld = 1'b0;
    i_eol = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || o_vld) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    n_cmp++;
    if (o_vld !== 1'b0 || i_rdy !== 1'b1) begin
      n_bad++;
      $display("FAIL R11 reset state: got o_vld=%0b i_rdy=%0b exp o_vld=0 i_rdy=1", o_vld, i_rdy);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int f = 0; f < 8; f++) begin
      for (int s = 0; s < 2; s++) begin
        cfg_fmt  = 3'(f);
        cfg_swap = s[0];
        for (int ln = 0; ln < 5; ln++) begin
          int len;
          len = (ln < 4) ? ln + 1 + 4 * s : $urandom_range(1, 9);
          for (int p = 0; p < len; p++) send_pix(p == len - 1);
        end
        drain();
      end
    end
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 words missing: got %0d left exp 0", exp_q.size());
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 150000) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got timeout exp completion");
      done = 1'b1;
    end
  end

  initial begin
    wait (done);
    repeat (3) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule